// File: doc/BRIEF.md
# Interrupt Cycle Controller

This block sits in the control unit of a small accumulator machine. It chooses, at the start of each instruction, between the normal fetch steps and an interrupt cycle, and it carries out that interrupt cycle. While an instruction executes (any timing step from 3 upward), it samples the interrupt enable and the input-ready and output-done flags into a pending-request flip-flop. When that flip-flop is set at the next step 0, the fetch is suppressed. A three-step sequence then replaces it. That sequence stores the program counter at memory location 0, points the program counter at location 1 and disables interrupts.

The step number comes from an external sequence counter. The block returns a counter-clear strobe at the end of its sequence. It drives load and clear strobes for the address register and the program counter, a memory write strobe with the saved return address as write data, and a fetch-enable that the normal fetch logic must be qualified by. The interrupt enable lives here. It is set and cleared by strobes from the instruction decoder. Because the interrupt cycle clears it, a service routine must re-enable interrupts itself before it can be interrupted.

Top module: `irq_cycle_ctrl`

## Requirements
- R1: After reset, `irq_pend` and `ien` are 0, and `ar_clr`, `ret_ld`, `mem_we`, `pc_clr`, `pc_inr` and `sc_clr` are all 0.
- R2: If `step` ≥ 3, `ien` is 1 and `fgi` or `fgo` is 1, then `irq_pend` is 1 after the next clock edge.
- R3: While `step` is 0, 1 or 2, the flags never set `irq_pend`.
- R4: While `ien` is 0, the flags have no effect: `irq_pend` stays 0 and `fetch_ok` stays asserted in steps 0 to 2.
- R5: `fetch_ok` is 1 exactly when `step` is 0, 1 or 2 and `irq_pend` is 0.
- R6: With `irq_pend` at 1 and `step` at 0, `ar_clr` and `ret_ld` are 1. The value of `pc` is captured at that edge as the return address.
- R7: With `irq_pend` at 1 and `step` at 1, `mem_we` and `pc_clr` are 1. `mem_wdata` then equals the captured return address, zero-extended to the data width.
- R8: With `irq_pend` at 1 and `step` at 2, `pc_inr` and `sc_clr` are 1. After that edge, both `irq_pend` and `ien` are 0.
- R9: `ion_set` sets `ien` and `iof_clr` clears it at the next edge. The end of an interrupt cycle clears `ien` even if `ion_set` is asserted in the same cycle.
- R10: Once set, `irq_pend` stays 1 until the end of the interrupt cycle, even if the flags fall or `ien` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | SC_W | Current timing step from the sequence counter |
| fgi | input | 1 | Input data ready flag |
| fgo | input | 1 | Output done flag |
| ion_set | input | 1 | Enable interrupts (from decode) |
| iof_clr | input | 1 | Disable interrupts (from decode) |
| pc | input | AW | Current program counter value |
| fetch_ok | output | 1 | Qualifies the normal fetch steps |
| ar_clr | output | 1 | Clear the address register |
| ret_ld | output | 1 | Capture the program counter as return address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Return address to be written |
| pc_clr | output | 1 | Clear the program counter |
| pc_inr | output | 1 | Increment the program counter |
| sc_clr | output | 1 | Clear the sequence counter |
| ien | output | 1 | Interrupt enable state |
| irq_pend | output | 1 | Pending interrupt request (R) |

## Verification
The assertions check on every cycle the state rules of the request and enable flops. They confirm that a qualifying execute-step sample sets the request, that fetch steps and a disabled enable leave it clear, that it holds until the closing step, that the closing step clears both flops, and that the three strobe groups never overlap. Only the bench scenarios can show the data side of the sequence. That includes the program counter value written at the store step being the one seen at the save step rather than a later one, the fetch qualifier tracking the step, and the clear taking priority over a simultaneous enable request.

// File: rtl/irq_cyc_pkg.sv
package irq_cyc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAVE   = 2'd1,
    PH_STORE  = 2'd2,
    PH_BRANCH = 2'd3
  } icyc_phase_e;
endpackage

// File: rtl/irq_step_decode.sv
module irq_step_decode
  import irq_cyc_pkg::*;
#(
  parameter int SC_W        = 4,
  parameter int FETCH_STEPS = 3
) (
  input  logic [SC_W-1:0] step,
  input  logic            pend,
  output icyc_phase_e     phase,
  output logic            fetch_ok,
  output logic            exec_step
);
  localparam logic [SC_W-1:0] S0 = SC_W'(0);
  localparam logic [SC_W-1:0] S1 = SC_W'(1);
  localparam logic [SC_W-1:0] S2 = SC_W'(2);
  localparam logic [SC_W-1:0] SF = SC_W'(FETCH_STEPS);

  always_comb begin
    exec_step = (step >= SF);
    fetch_ok  = !exec_step && !pend;
    phase     = PH_IDLE;
    if (pend) begin
      if (step == S0)      phase = PH_SAVE;
      else if (step == S1) phase = PH_STORE;
      else if (step == S2) phase = PH_BRANCH;
      else                 phase = PH_IDLE;
    end
  end
endmodule

// File: rtl/irq_state_regs.sv
module irq_state_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic exec_step,
  input  logic fgi,
  input  logic fgo,
  input  logic ion_set,
  input  logic iof_clr,
  input  logic cyc_done,
  output logic ien_q,
  output logic pend_q
);
  logic ien_d, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (cyc_done)
      pend_d = 1'b0;
    else if (exec_step && ien_q && (fgi || fgo))
      pend_d = 1'b1;

    ien_d = ien_q;
    if (cyc_done || iof_clr)
      ien_d = 1'b0;
    else if (ion_set)
      ien_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      ien_q  <= ien_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/irq_ret_reg.sv
module irq_ret_reg #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);
  logic [AW-1:0] q_d;

  always_comb q_d = ld ? d : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/irq_cycle_ctrl.sv
module irq_cycle_ctrl
  import irq_cyc_pkg::*;
#(
  parameter int SC_W = 4,
  parameter int AW   = 12,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SC_W-1:0] step,
  input  logic            fgi,
  input  logic            fgo,
  input  logic            ion_set,
  input  logic            iof_clr,
  input  logic [AW-1:0]   pc,
  output logic            fetch_ok,
  output logic            ar_clr,
  output logic            ret_ld,
  output logic            mem_we,
  output logic [DW-1:0]   mem_wdata,
  output logic            pc_clr,
  output logic            pc_inr,
  output logic            sc_clr,
  output logic            ien,
  output logic            irq_pend
);
  localparam int FETCH_STEPS = 3;
  localparam int PAD_W       = DW - AW;

  icyc_phase_e   phase;
  logic          exec_step;
  logic          cyc_done;
  logic [AW-1:0] ret_q;

  irq_step_decode #(.SC_W(SC_W), .FETCH_STEPS(FETCH_STEPS)) u_dec (
    .step      (step),
    .pend      (irq_pend),
    .phase     (phase),
    .fetch_ok  (fetch_ok),
    .exec_step (exec_step)
  );

  always_comb begin
    ar_clr   = (phase == PH_SAVE);
    ret_ld   = (phase == PH_SAVE);
    mem_we   = (phase == PH_STORE);
    pc_clr   = (phase == PH_STORE);
    pc_inr   = (phase == PH_BRANCH);
    sc_clr   = (phase == PH_BRANCH);
    cyc_done = (phase == PH_BRANCH);
  end

  irq_state_regs u_st (
    .clk       (clk),
    .rst_n     (rst_n),
    .exec_step (exec_step),
    .fgi       (fgi),
    .fgo       (fgo),
    .ion_set   (ion_set),
    .iof_clr   (iof_clr),
    .cyc_done  (cyc_done),
    .ien_q     (ien),
    .pend_q    (irq_pend)
  );

  irq_ret_reg #(.AW(AW)) u_ret (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (ret_ld),
    .d     (pc),
    .q     (ret_q)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign mem_wdata = {{PAD_W{1'b0}}, ret_q};
    end else begin : g_trunc
      assign mem_wdata = ret_q[DW-1:0];
    end
  endgenerate
endmodule

// File: rtl/irq_cycle_ctrl_chk.sv
module irq_cycle_ctrl_chk #(
  parameter int SC_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [SC_W-1:0] step,
  input logic            fgi,
  input logic            fgo,
  input logic            ien,
  input logic            irq_pend,
  input logic            ar_clr,
  input logic            mem_we,
  input logic            pc_inr
);
  localparam logic [SC_W-1:0] S2 = SC_W'(2);
  localparam logic [SC_W-1:0] S3 = SC_W'(3);

  assert_req_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step >= S3 && ien && (fgi || fgo)) |=> irq_pend);

  assert_no_set_in_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step < S3 && !irq_pend) |=> !irq_pend);

  assert_flags_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien && !irq_pend) |=> !irq_pend);

  assert_phase_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ar_clr, mem_we, pc_inr}));

  assert_cycle_end_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && step == S2) |=> (!irq_pend && !ien));

  assert_req_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && step != S2) |=> irq_pend);
endmodule

bind irq_cycle_ctrl irq_cycle_ctrl_chk #(.SC_W(SC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .step     (step),
  .fgi      (fgi),
  .fgo      (fgo),
  .ien      (ien),
  .irq_pend (irq_pend),
  .ar_clr   (ar_clr),
  .mem_we   (mem_we),
  .pc_inr   (pc_inr)
);

// File: tb/tb_irq_cycle_ctrl.sv
`timescale 1ns/1ps
module tb_irq_cycle_ctrl;
  localparam int SC_W = 4;
  localparam int AW   = 12;
  localparam int DW   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [SC_W-1:0] step = '0;
  logic fgi = 1'b0, fgo = 1'b0, ion_set = 1'b0, iof_clr = 1'b0;
  logic [AW-1:0] pc = '0;
  logic fetch_ok, ar_clr, ret_ld, mem_we, pc_clr, pc_inr, sc_clr, ien, irq_pend;
  logic [DW-1:0] mem_wdata;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_cycle_ctrl #(.SC_W(SC_W), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .step(step), .fgi(fgi), .fgo(fgo),
    .ion_set(ion_set), .iof_clr(iof_clr), .pc(pc), .fetch_ok(fetch_ok),
    .ar_clr(ar_clr), .ret_ld(ret_ld), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .pc_clr(pc_clr), .pc_inr(pc_inr), .sc_clr(sc_clr), .ien(ien),
    .irq_pend(irq_pend)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic set_in(input int s, input bit i, input bit o);
    step = SC_W'(s); fgi = i; fgo = o;
    #1;
  endtask

  task automatic t_reset();
    set_in(0, 0, 0);
    check("R1 pend", irq_pend, 0);
    check("R1 ien", ien, 0);
    check("R1 strobes", {ar_clr, ret_ld, mem_we, pc_clr, pc_inr, sc_clr}, 0);
    check("R5 fetch_ok step0", fetch_ok, 1);
  endtask

  task automatic t_enable();
    ion_set = 1; tick(); ion_set = 0;
    check("R9 ien set", ien, 1);
  endtask

  task automatic t_fetch_steps();
    for (int s = 0; s < 3; s++) begin
      set_in(s, 1, 1); tick();
      check("R3 no set in fetch", irq_pend, 0);
    end
    set_in(0, 0, 0);
  endtask

  task automatic t_disabled();
    iof_clr = 1; tick(); iof_clr = 0;
    check("R9 ien cleared", ien, 0);
    set_in(5, 1, 1); tick();
    check("R4 pend stays 0", irq_pend, 0);
    set_in(1, 0, 0);
    check("R4 fetch_ok step1", fetch_ok, 1);
    set_in(7, 0, 0);
    check("R5 fetch_ok exec", fetch_ok, 0);
  endtask

  task automatic t_interrupt();
    ion_set = 1; tick(); ion_set = 0;
    set_in(4, 0, 1); tick();
    check("R2 pend set", irq_pend, 1);
    set_in(6, 0, 0); iof_clr = 1; tick(); iof_clr = 0;
    check("R10 pend holds", irq_pend, 1);
    ion_set = 1; tick(); ion_set = 0;
    pc = 12'h3A5; set_in(0, 0, 0);
    check("R5 fetch blocked", fetch_ok, 0);
    check("R6 ar_clr", ar_clr, 1);
    check("R6 ret_ld", ret_ld, 1);
    check("R6 no write", mem_we, 0);
    tick();
    pc = 12'h111; set_in(1, 0, 0);
    check("R7 mem_we", mem_we, 1);
    check("R7 pc_clr", pc_clr, 1);
    check("R7 wdata", mem_wdata, 16'h03A5);
    check("R10 pend during cycle", irq_pend, 1);
    tick();
    set_in(2, 1, 1); ion_set = 1;
    check("R8 pc_inr", pc_inr, 1);
    check("R8 sc_clr", sc_clr, 1);
    tick(); ion_set = 0;
    check("R8 pend cleared", irq_pend, 0);
    check("R9 clear beats set", ien, 0);
    set_in(0, 0, 0);
    check("R5 fetch resumes", fetch_ok, 1);
    check("R1 strobes idle", {ar_clr, mem_we, pc_inr}, 0);
  endtask

  task automatic t_fgi_path();
    ion_set = 1; tick(); ion_set = 0;
    set_in(3, 1, 0); tick();
    check("R2 fgi sets", irq_pend, 1);
    for (int s = 0; s < 3; s++) begin
      set_in(s, 0, 0); tick();
    end
    check("R8 second cycle end", irq_pend, 0);
  endtask

  initial begin
    #160000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    tick();
    t_reset();
    t_enable();
    t_fetch_steps();
    t_disabled();
    t_interrupt();
    t_fgi_path();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule